// File: doc/BRIEF.md
# Strobe-Kicked Watchdog Timer

This block watches a strobe input that running software must keep toggling. A falling edge on the strobe restarts a down-counter. If the counter runs out before the next falling edge, the block raises a single-cycle `timeout` pulse, and a separate reset controller turns that pulse into a full system reset. Software cannot switch the watchdog off. It can only keep it fed.

A 2-bit code picks one of three fixed periods. The code comes from a pin that may be tied low, left floating or tied high, and each level selects its own period. The nominal periods are 150 ms, 600 ms and 1.2 s, and the default tick counts match those values at a 250 MHz clock. The counter runs only while the reset controller reports that reset is released. While reset is active the counter waits at the full period, so timing starts from a fresh count as soon as reset lifts. The strobe is asynchronous and passes through a two-flop synchroniser before edge detection.

Top module: `strobe_watchdog`

## Requirements
- R1: During a synchronous reset (`rst` high) and on the cycle after it, `timeout` is low.
- R2: Select code 2'b00 sets a period of `TICKS_LOW` clock edges. With `rel_ok` high and no strobe kick, `timeout` is high during the cycle that follows the `TICKS_LOW`-th rising edge counted from the first edge that samples `rel_ok` high.
- R3: Select code 2'b01 sets a period of `TICKS_FLOAT` edges. Code 2'b11 behaves exactly like 2'b01.
- R4: Select code 2'b10 sets a period of `TICKS_HIGH` edges.
- R5: `timeout` is high for exactly one cycle. If `rel_ok` stays high, the counter reloads the full period and expires again every period.
- R6: A kick is the strobe sampled high at one clock edge and low at the next edge. A kick reloads the counter two edges after the low sample, and the next expiry then comes a full period later. A low that lasts for a single sample is enough.
- R7: A steady strobe level, high or low, does not restart the count, and neither does a rising edge.
- R8: When a kick reloads the counter on the edge where it would otherwise expire, no `timeout` pulse is produced.
- R9: While `rel_ok` is low, `timeout` stays low, strobe edges have no effect, and the counter is held at the full period. The first expiry after release comes one full period later.
- R10: A change of the select code does not alter a count already in progress. The new period applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_in | input | 1 | Asynchronous strobe from software; a falling edge kicks the watchdog |
| period_sel | input | 2 | Period code: 00 short, 01 middle, 10 long, 11 as 01 |
| rel_ok | input | 1 | High while the system reset is released; counting is enabled only then |
| timeout | output | 1 | Registered single-cycle pulse on expiry |

## Verification
The watchdog runs free under each of the four select codes, and counting the pulses in a fixed window separates the three periods and shows that code 11 aliases code 01. A regular train of single-sample low strobe pulses, placed well inside the period, must keep `timeout` silent. This separates a correct falling-edge restart from a design that ignores the strobe. A long steady low followed by a steady high must still let the counter expire, which exposes a design that restarts on a level or on a rising edge. A kick placed on the exact expiry edge, a select change in the middle of a count and a strobe edge sent during a reset hold probe the priority order, the point where a new period takes effect, and the hold-off. A cycle-accurate model compares `timeout` on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT  = 2'b00,
    SEL_MIDDLE = 2'b01,
    SEL_LONG   = 2'b10,
    SEL_ALIAS  = 2'b11
  } wdt_sel_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic kick
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= strobe_in;
  end

  genvar gi;
  generate
    for (gi = 1; gi < CHAIN; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b0;
        else     chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  // Falling edge seen on the synchronised strobe: older sample high, newer low.
  assign kick = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

  // A single falling edge can be reported only once.
  assert_edge_once_R7: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick);

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned TICKS_SHORT  = 16,
  parameter int unsigned TICKS_MIDDLE = 64,
  parameter int unsigned TICKS_LONG   = 128
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] reload
);

  always_comb begin
    unique case (wdt_sel_e'(sel))
      SEL_SHORT:  reload = CNT_W'(TICKS_SHORT);
      SEL_LONG:   reload = CNT_W'(TICKS_LONG);
      SEL_MIDDLE,
      SEL_ALIAS:  reload = CNT_W'(TICKS_MIDDLE);
      default:    reload = CNT_W'(TICKS_MIDDLE);
    endcase
  end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= reload;
      expire <= 1'b0;
    end else if (!run || kick) begin
      cnt_q  <= reload;
      expire <= 1'b0;
    end else if (last_tick) begin
      cnt_q  <= reload;
      expire <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      expire <= 1'b0;
    end
  end

  // The pulse never lasts two cycles (periods are at least two ticks).
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  // The count never sits at zero.
  assert_cnt_live_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);

  // Held off while reset is active.
  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !expire);

  // A kick always wins over expiry.
  assert_kick_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (run && kick) |=> !expire);

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_SHORT  = 37_500_000,
  parameter int unsigned TICKS_MIDDLE = 150_000_000,
  parameter int unsigned TICKS_LONG   = 300_000_000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_in,
  input  logic [1:0] period_sel,
  input  logic       rel_ok,
  output logic       timeout
);

  localparam int unsigned MAX_TICKS = max3(TICKS_SHORT, TICKS_MIDDLE, TICKS_LONG);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             kick;
  logic [CNT_W-1:0] reload;

  wdt_strobe_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_in(strobe_in),
    .kick     (kick)
  );

  wdt_period_sel #(
    .CNT_W       (CNT_W),
    .TICKS_SHORT (TICKS_SHORT),
    .TICKS_MIDDLE(TICKS_MIDDLE),
    .TICKS_LONG  (TICKS_LONG)
  ) u_sel (
    .sel   (period_sel),
    .reload(reload)
  );

  wdt_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (rel_ok),
    .kick  (kick),
    .reload(reload),
    .expire(timeout)
  );

  // The output follows only cycles in which counting was enabled.
  assert_needs_release_R9: assert property (@(posedge clk) disable iff (rst)
    timeout |-> $past(rel_ok));

endmodule

// File: tb/strobe_watchdog_bench.sv
`timescale 1ns/1ps
module strobe_watchdog_bench;

  localparam int unsigned T_S = 16;
  localparam int unsigned T_M = 29;
  localparam int unsigned T_L = 47;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_in = 1'b1;
  logic [1:0] period_sel = 2'b00;
  logic       rel_ok = 1'b0;
  logic       timeout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tout_seen = 0;
  string req = "R1";

  // Model state
  bit hist[$];
  int m_rem;
  bit m_tout = 1'b0;
  bit done = 1'b0;

  strobe_watchdog #(
    .TICKS_SHORT(T_S), .TICKS_MIDDLE(T_M), .TICKS_LONG(T_L)
  ) u_strobe_watchdog (
    .clk(clk), .rst(rst), .strobe_in(strobe_in),
    .period_sel(period_sel), .rel_ok(rel_ok), .timeout(timeout)
  );

  always #2 clk = ~clk;

  function automatic int period_of(input logic [1:0] s);
    if (s == 2'b00) return T_S;
    if (s == 2'b10) return T_L;
    return T_M;
  endfunction

  // Behavioural reference: strobe history queue plus remaining-ticks integer.
  always @(posedge clk) begin
    bit k;
    cycles++;
    if (rst) begin
      hist = '{0, 0, 0};
      m_rem = period_of(period_sel);
      m_tout = 0;
    end else begin
      k = (hist[2] == 1) && (hist[1] == 0);
      hist.push_front(strobe_in);
      void'(hist.pop_back());
      if (!rel_ok || k) begin
        m_rem = period_of(period_sel);
        m_tout = 0;
      end else if (m_rem == 1) begin
        m_rem = period_of(period_sel);
        m_tout = 1;
      end else begin
        m_rem = m_rem - 1;
        m_tout = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (timeout === 1'b1) tout_seen++;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      checks++;
      if (timeout !== m_tout) begin
        failures++;
        $display("FAIL %s cycle %0d timeout actual=%b expected=%b", req, cycles, timeout, m_tout);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input bit c, input int act);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s actual=%0d expected=condition true", tag, act);
    end
  endtask

  task automatic rearm(input logic [1:0] s);
    rel_ok = 1'b0;
    period_sel = s;
    step(3);
    rel_ok = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog for the run itself.
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<100000 cycles", cycles);
    finish_run();
  end

  initial begin
    int base;
    // R1: reset state
    req = "R1";
    step(4);
    check_eq("R1 timeout during reset", timeout, 0);
    rst = 1'b0;
    step(1);
    check_eq("R1 timeout after reset", timeout, 0);

    // R9: held while reset active, strobe edges ignored
    req = "R9";
    base = tout_seen;
    for (int i = 0; i < 5; i++) begin
      strobe_in = 1'b0; step(3);
      strobe_in = 1'b1; step(3);
    end
    check_eq("R9 no pulse while held", tout_seen - base, 0);

    // R2 / R5: short period free run
    req = "R2";
    rel_ok = 1'b1;
    base = tout_seen;
    step(15);
    check_eq("R2 no pulse before short period", tout_seen - base, 0);
    step(1);
    check_eq("R2 pulse at short period", tout_seen - base, 1);
    req = "R5";
    step(1);
    check_eq("R5 pulse one cycle wide", timeout, 0);
    step(T_S * 2 + 3);
    check_eq("R5 repeats every period", tout_seen - base, 3);

    // R3: middle period and alias code
    req = "R3";
    rearm(2'b01);
    base = tout_seen;
    step(T_M * 2 + 3);
    check_eq("R3 middle period count", tout_seen - base, 2);
    rearm(2'b11);
    base = tout_seen;
    step(T_M * 2 + 3);
    check_eq("R3 code 11 aliases middle", tout_seen - base, 2);

    // R4: long period
    req = "R4";
    rearm(2'b10);
    base = tout_seen;
    step(T_L - 1);
    check_eq("R4 no pulse before long period", tout_seen - base, 0);
    step(1);
    check_eq("R4 pulse at long period", tout_seen - base, 1);

    // R6: single-sample kicks inside the period keep it quiet
    req = "R6";
    rearm(2'b01);
    base = tout_seen;
    for (int i = 0; i < 15; i++) begin
      step(19);
      strobe_in = 1'b0; step(1);
      strobe_in = 1'b1;
    end
    check_eq("R6 regular kicks prevent timeout", tout_seen - base, 0);
    // multi-cycle low kicks also restart once each
    for (int i = 0; i < 6; i++) begin
      step(10);
      strobe_in = 1'b0; step(8);
      strobe_in = 1'b1;
    end
    check_eq("R6 long-low kicks prevent timeout", tout_seen - base, 0);

    // R7: steady levels and rising edges do not restart
    req = "R7";
    rearm(2'b00);
    strobe_in = 1'b0;
    base = tout_seen;
    step(T_S * 3);
    check_true("R7 steady low lets it expire", (tout_seen - base) >= 2, tout_seen - base);
    base = tout_seen;
    strobe_in = 1'b1;
    step(T_S * 3);
    check_true("R7 rising edge and steady high let it expire", (tout_seen - base) >= 2,
               tout_seen - base);

    // R8: kick lands exactly on the expiry edge
    req = "R8";
    rearm(2'b00);
    strobe_in = 1'b1;
    step(2);
    while (m_rem != 3) step(1);
    base = tout_seen;
    strobe_in = 1'b0;
    step(6);
    check_eq("R8 kick on expiry edge suppresses pulse", tout_seen - base, 0);
    strobe_in = 1'b1;

    // R10: select change mid count
    req = "R10";
    rearm(2'b00);
    base = tout_seen;
    step(5);
    period_sel = 2'b10;
    step(11);
    check_eq("R10 current count keeps old period", tout_seen - base, 1);
    step(T_L - 1);
    check_eq("R10 no early pulse under new period", tout_seen - base, 1);
    step(1);
    check_eq("R10 new period from next reload", tout_seen - base, 2);

    // R9: hold mid count, strobe edge during hold, full period after release
    req = "R9";
    rearm(2'b00);
    step(8);
    rel_ok = 1'b0;
    strobe_in = 1'b0; step(3);
    strobe_in = 1'b1; step(7);
    base = tout_seen;
    rel_ok = 1'b1;
    step(T_S - 1);
    check_eq("R9 no pulse before full period after release", tout_seen - base, 0);
    step(1);
    check_eq("R9 pulse one full period after release", tout_seen - base, 1);

    step(2);
    finish_run();
  end

endmodule